// File: doc/BRIEF.md
# Edge-Selectable Port Interrupt Unit

This block watches an 8-bit input port and turns pin transitions into a single interrupt request. Each pin carries three bits of state: an enable, a polarity select and a sticky flag. Every pin is first brought into the clock domain through a two-stage synchronizer. A transition of the chosen direction then sets that pin's flag. The flag stays set until software writes it back to zero.

The request output is high whenever any flag is set while its enable is also set. One request serves the whole port, so the interrupt handler reads the flag register to find out which pin caused it. A small register interface has a combinational read path and a single-cycle write strobe. Through it, software can read the synchronized pin levels, and it can read or write the enable, polarity and flag registers. Writing the flag register loads the written value, so a handler can clear flags or set them directly.

Edges are detected on the pin level after it has been XORed with the polarity bit. As a result, changing a pin's polarity bit counts as a transition whenever the pin already sits at the level the new edge would produce. A stray flag can appear on such a change, and software should clear the flags after it reprograms the polarity register.

Top module: `port_irq_unit`

## Requirements
- R1: After reset, the enable, polarity and flag registers read 0 and `irq` is 0.
- R2: With polarity bit 0, a low-to-high transition on a pin sets that pin's flag, which is bit i of the flag register at address 3.
- R3: With polarity bit 1 (address 2), a high-to-low transition sets the flag and a low-to-high transition leaves it clear.
- R4: A flag is set whether or not its enable bit (address 1) is set. `irq` stays 0 while the flag's enable bit is 0, and it rises once the enable bit is written to 1.
- R5: `irq` is 1 exactly when at least one pin has both its flag and its enable bit set.
- R6: A flag stays set after the pin returns to its earlier level. Only a write of 0 to that bit clears it.
- R7: A write to address 3 loads the flag register with the written data. A bit written as 1 is set and raises `irq` if it is enabled.
- R8: If a write that clears a flag arrives in the same cycle as a detected edge on that pin, the flag ends up set.
- R9: Setting a pin's polarity bit while the pin is low sets its flag, because the new edge condition already holds.
- R10: A pin change shows at address 0 two clock edges after it is driven. The flag rises on the third edge and not earlier.
- R11: Address 0 is read-only and returns the synchronized pin levels. Writes to it have no effect. Addresses 1 and 2 read back their last written values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 8 | Asynchronous port pins |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 2 | Register select: 0 pins, 1 enable, 2 polarity, 3 flags |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Port interrupt request |

## Verification
The pins are driven with rising edges and then falling edges under both polarity settings. This separates a correct polarity from an inverted one, and it shows that the opposite edge leaves the flag clear. Several pins are raised together under different enable masks. Each flag is then cleared one at a time, which shows whether the request follows the OR of the enabled flags or just a single pin. Exact reads at two and three edges after a pin change fix the depth of the synchronizer. Three further patterns each catch a design that drops a pending edge or ignores the polarity register as a source of edges: a clear timed into the cycle of a live edge, direct flag writes, and a polarity change over a low pin.

// File: rtl/port_irq_pkg.sv
package port_irq_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_PINS     = 2'd0,
    REG_ENABLE   = 2'd1,
    REG_POLARITY = 2'd2,
    REG_FLAGS    = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/port_irq_sync.sv
module port_irq_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int unsigned LAST = STAGES - 1;

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= din;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout = stage_q[LAST];
endmodule

// File: rtl/port_irq_edge.sv
module port_irq_edge #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level,
  input  logic [WIDTH-1:0] polarity,
  output logic [WIDTH-1:0] hit
);
  // Level seen through the polarity: 1 means "after the selected edge".
  function automatic logic [WIDTH-1:0] oriented(input logic [WIDTH-1:0] lvl,
                                                input logic [WIDTH-1:0] pol);
    return lvl ^ pol;
  endfunction

  function automatic logic [WIDTH-1:0] rises(input logic [WIDTH-1:0] now_v,
                                             input logic [WIDTH-1:0] before_v);
    return now_v & ~before_v;
  endfunction

  logic [WIDTH-1:0] oriented_now;
  logic [WIDTH-1:0] oriented_q;

  assign oriented_now = oriented(level, polarity);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oriented_q <= '0;
    else        oriented_q <= oriented_now;
  end

  assign hit = rises(oriented_now, oriented_q);
endmodule

// File: rtl/port_irq_flags.sv
module port_irq_flags #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] hit,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] flags
);
  // An edge always wins over a software load in the same cycle.
  function automatic logic [WIDTH-1:0] next_flags(input logic [WIDTH-1:0] cur,
                                                  input logic [WIDTH-1:0] edges,
                                                  input logic             ld,
                                                  input logic [WIDTH-1:0] val);
    return (ld ? val : cur) | edges;
  endfunction

  logic [WIDTH-1:0] flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= next_flags(flag_q, hit, load, load_val);
  end

  assign flags = flag_q;
endmodule

// File: rtl/port_irq_unit.sv
module port_irq_unit
  import port_irq_pkg::*;
#(
  parameter int unsigned NPINS       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_in,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  output logic              irq
);
  function automatic logic request_of(input logic [NPINS-1:0] fl,
                                      input logic [NPINS-1:0] en);
    return |(fl & en);
  endfunction

  reg_sel_e         sel;
  logic [NPINS-1:0] pin_sync;
  logic [NPINS-1:0] en_q;
  logic [NPINS-1:0] pol_q;
  logic [NPINS-1:0] flag_q;
  logic [NPINS-1:0] edge_hit;
  logic             wr_enable;
  logic             wr_polarity;
  logic             wr_flag;

  assign sel         = reg_sel_e'(bus_addr);
  assign wr_enable   = bus_wr && (sel == REG_ENABLE);
  assign wr_polarity = bus_wr && (sel == REG_POLARITY);
  assign wr_flag     = bus_wr && (sel == REG_FLAGS);

  port_irq_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pin_in),
    .dout (pin_sync)
  );

  port_irq_edge #(.WIDTH(NPINS)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level   (pin_sync),
    .polarity(pol_q),
    .hit     (edge_hit)
  );

  port_irq_flags #(.WIDTH(NPINS)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (edge_hit),
    .load    (wr_flag),
    .load_val(bus_wdata),
    .flags   (flag_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      pol_q <= '0;
    end else begin
      if (wr_enable)   en_q  <= bus_wdata;
      if (wr_polarity) pol_q <= bus_wdata;
    end
  end

  always_comb begin
    unique case (sel)
      REG_PINS:     bus_rdata = pin_sync;
      REG_ENABLE:   bus_rdata = en_q;
      REG_POLARITY: bus_rdata = pol_q;
      REG_FLAGS:    bus_rdata = flag_q;
      default:      bus_rdata = '0;
    endcase
  end

  assign irq = request_of(flag_q, en_q);
endmodule

// File: rtl/port_irq_unit_chk.sv
module port_irq_unit_chk #(
  parameter int unsigned NPINS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] edge_hit,
  input logic [NPINS-1:0] flag_q,
  input logic [NPINS-1:0] en_q,
  input logic             wr_flag,
  input logic [NPINS-1:0] wdata,
  input logic             irq
);
  p_hit_sets_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit != '0) |=> ((flag_q & $past(edge_hit)) == $past(edge_hit)));

  p_edge_beats_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flag && ((edge_hit & ~wdata) != '0)) |=>
      ((flag_q & $past(edge_hit)) == $past(edge_hit)));

  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_flag |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  p_no_stray_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_flag |=> ((flag_q & ~$past(flag_q) & ~$past(edge_hit)) == '0));

  p_write_loads_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flag && (edge_hit == '0)) |=> (flag_q == $past(wdata)));

  p_quiet_if_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);
endmodule

bind port_irq_unit port_irq_unit_chk #(.NPINS(NPINS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .edge_hit(edge_hit),
  .flag_q  (flag_q),
  .en_q    (en_q),
  .wr_flag (wr_flag),
  .wdata   (bus_wdata),
  .irq     (irq)
);

// File: tb/port_irq_unit_test.sv
module port_irq_unit_test;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned NPINS      = 8;

  typedef struct {
    logic [1:0]       addr;
    logic [NPINS-1:0] data;
    logic             irq;
    string            tag;
  } expect_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NPINS-1:0] pin_in = '0;
  logic             bus_wr = 1'b0;
  logic [1:0]       bus_addr = '0;
  logic [NPINS-1:0] bus_wdata = '0;
  logic [NPINS-1:0] bus_rdata;
  logic             irq;
  logic             probe = 1'b0;

  expect_t sb_q [$];
  int applied = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  port_irq_unit uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_in   (pin_in),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq      (irq)
  );

  // Monitor: samples away from the active edge and pops the scoreboard.
  always @(negedge clk) begin
    if (probe && sb_q.size() > 0) begin
      expect_t e;
      e = sb_q.pop_front();
      applied++;
      if (bus_rdata !== e.data || irq !== e.irq) begin
        miscompares++;
        $display("FAIL %s: addr %0d rdata=%02h irq=%0b expected rdata=%02h irq=%0b",
                 e.tag, e.addr, bus_rdata, irq, e.data, e.irq);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [NPINS-1:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    step(1);
    bus_wr    = 1'b0;
  endtask

  task automatic expect_read(input logic [1:0] a, input logic [NPINS-1:0] d,
                             input logic i, input string tag);
    expect_t e;
    e.addr = a; e.data = d; e.irq = i; e.tag = tag;
    sb_q.push_back(e);
    bus_addr = a;
    probe    = 1'b1;
    step(1);
    probe    = 1'b0;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);

    expect_read(2'd1, 8'h00, 1'b0, "R1 enable after reset");
    expect_read(2'd2, 8'h00, 1'b0, "R1 polarity after reset");
    expect_read(2'd3, 8'h00, 1'b0, "R1 flags after reset");

    // Rising edge on pin 0, polarity 0; exact synchronizer timing.
    pin_in = 8'h01;
    step(2);
    expect_read(2'd3, 8'h00, 1'b0, "R10 flag not yet set after two edges");
    expect_read(2'd3, 8'h01, 1'b0, "R2 rising edge sets flag (R4 masked, no irq)");
    expect_read(2'd0, 8'h01, 1'b0, "R10 synchronized pin visible");

    reg_write(2'd1, 8'h01);
    expect_read(2'd3, 8'h01, 1'b1, "R4 enabling pending flag raises irq");

    pin_in = 8'h00;
    step(4);
    expect_read(2'd3, 8'h01, 1'b1, "R6 flag sticky after pin returns");

    reg_write(2'd3, 8'h00);
    expect_read(2'd3, 8'h00, 1'b0, "R6 software write of 0 clears flag");

    // Polarity change over a low pin raises a stray flag.
    reg_write(2'd2, 8'h02);
    step(3);
    expect_read(2'd3, 8'h02, 1'b0, "R9 polarity change sets flag");
    reg_write(2'd3, 8'h00);

    pin_in = 8'h02;
    step(4);
    expect_read(2'd3, 8'h00, 1'b0, "R3 rising edge ignored with polarity 1");
    pin_in = 8'h00;
    step(4);
    expect_read(2'd3, 8'h02, 1'b0, "R3 falling edge sets flag with polarity 1");

    // Several pins, different enable masks.
    reg_write(2'd1, 8'h0C);
    pin_in = 8'h0C;
    step(4);
    expect_read(2'd3, 8'h0E, 1'b1, "R5 multiple flags, enabled ones request");
    reg_write(2'd3, 8'h06);
    expect_read(2'd3, 8'h06, 1'b1, "R5 one enabled flag still requests");
    reg_write(2'd3, 8'h02);
    expect_read(2'd3, 8'h02, 1'b0, "R5 only disabled flag left, no request");

    // Direct flag set by software.
    reg_write(2'd1, 8'h80);
    reg_write(2'd3, 8'h80);
    expect_read(2'd3, 8'h80, 1'b1, "R7 software set raises irq");
    reg_write(2'd3, 8'h00);
    expect_read(2'd3, 8'h00, 1'b0, "R7 software load of 0");

    // Clear in the same cycle as an edge on pin 4.
    reg_write(2'd1, 8'h00);
    pin_in = 8'h1C;
    step(2);
    reg_write(2'd3, 8'h00);
    expect_read(2'd3, 8'h10, 1'b0, "R8 edge wins over simultaneous clear");

    // Read-only pin register, readback of control registers.
    reg_write(2'd0, 8'hFF);
    expect_read(2'd0, 8'h1C, 1'b0, "R11 pin register ignores writes");
    expect_read(2'd1, 8'h00, 1'b0, "R11 enable readback");
    expect_read(2'd2, 8'h02, 1'b0, "R11 polarity readback");

    step(2);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end
endmodule